// File: doc/BRIEF.md
# Instruction Prefetch Queue Unit

This unit sits on the bus side of a processor and keeps a short first-in first-out queue of upcoming instruction bytes topped up. Meanwhile the execution side drains the queue, so fetching overlaps with execution. Each fetch address is a 20-bit physical address. It is formed by shifting a 16-bit code segment left by four bits and adding a 16-bit instruction offset. Any carry out of bit 19 is discarded. After each accepted byte the offset advances by one, wrapping inside its segment.

Instruction bytes are fetched over a request/acknowledge read port. `fetch_req` rises with a stable `fetch_addr`. The memory answers with a single-cycle `fetch_ack` carrying `fetch_data`, and it may do so in the same cycle the request is seen. The consumer side is a valid/ready stream: `byte_valid` is high whenever the queue holds a byte, and `byte_data` shows the oldest byte. A byte is removed in a cycle where both `byte_valid` and `byte_ready` are high. While `byte_ready` stays low, the head byte and `byte_valid` hold. Back-pressure from the consumer only stops fetching once the queue is full.

A control-flow change is signalled by a one-cycle `jump` pulse together with a new segment and offset. The queue empties in that cycle. Any acknowledge arriving in the same cycle is dropped. The next request goes out at the new address.

Top module: `pfq_top`

## Requirements
- R1: The queue never holds more than DEPTH (6) bytes, and `fetch_req` is low in every cycle in which the queue is full.
- R2: `fetch_addr` equals (segment × 16 + offset) mod 2^20. For example, 1005h:5555h gives 155A5h, and FFFFh:FFF8h gives 0FFE8h with the carry dropped.
- R3: The fetch offset increments by one per accepted byte and wraps from FFFFh to 0000h without changing the segment.
- R4: Bytes reach the consumer exactly once each, in the order they were acknowledged.
- R5: Once raised, `fetch_req` stays high with an unchanged `fetch_addr` until an acknowledge or a jump. An acknowledge while `fetch_req` is low has no effect.
- R6: `byte_valid` is high exactly when the queue is non-empty. While `byte_ready` is low, `byte_valid` and `byte_data` hold.
- R7: A `jump` empties the queue in its cycle and discards the data of an acknowledge in that same cycle. A consumer handshake in that cycle removes nothing. In the next cycle `byte_valid` is low and `fetch_req` is high at the new segment:offset.
- R8: During reset `fetch_req` and `byte_valid` are low. The first request after reset is at the reset segment:offset (F000h:FFF0h, address FFFF0h).
- R9: After an acknowledge that leaves a free slot, `fetch_req` stays high in the next cycle at the next offset, with no idle cycle.
- R10: When a byte is removed from a full queue, `fetch_req` is high in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| jump | input | 1 | Flush the queue and redirect fetching |
| jump_seg | input | 16 | New code segment, taken when `jump` is high |
| jump_off | input | 16 | New instruction offset, taken when `jump` is high |
| fetch_req | output | 1 | Read request to instruction memory |
| fetch_addr | output | 20 | Physical address of the requested byte |
| fetch_ack | input | 1 | Memory completes the pending request this cycle |
| fetch_data | input | 8 | Byte returned with `fetch_ack` |
| byte_valid | output | 1 | Queue head holds a byte |
| byte_data | output | 8 | Oldest queued byte |
| byte_ready | input | 1 | Consumer takes the head byte this cycle |

## Verification
The checker assumes that the memory raises `fetch_ack` only in cycles it chooses. It also assumes that `jump` may come at any time, including in the same cycle as an acknowledge or a consumer handshake. No assumption is made about when the consumer is ready. The bench drives every input half a cycle away from the sampling edge. Its memory model acknowledges after a swept latency of zero to three cycles, and it also injects stray acknowledges while no request is pending. Redirect targets are picked so that both the 20-bit carry and the 16-bit offset wrap happen while the queue runs under several consumer ready patterns.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
  localparam int SEG_W     = 16;
  localparam int OFF_W     = 16;
  localparam int SEG_SHIFT = 4;
  localparam int PADDR_W   = SEG_W + SEG_SHIFT;

  typedef logic [SEG_W-1:0]   seg_t;
  typedef logic [OFF_W-1:0]   off_t;
  typedef logic [PADDR_W-1:0] paddr_t;
endpackage

// File: rtl/pfq_addr.sv
module pfq_addr
  import pfq_pkg::*;
(
  input  seg_t   seg,
  input  off_t   off,
  output paddr_t paddr
);
  localparam int PAD_W = PADDR_W - OFF_W;

  // Both operands are PADDR_W wide; the sum is truncated, so the carry is lost.
  always_comb begin
    paddr = {seg, {SEG_SHIFT{1'b0}}} + {{PAD_W{1'b0}}, off};
  end
endmodule

// File: rtl/pfq_fifo.sv
module pfq_fifo #(
  parameter  int W     = 8,
  parameter  int DEPTH = 6,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     wdata,
  output logic [W-1:0]     rdata,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_nxt
);
  logic [W-1:0]     slot [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, wr_inc, rd_inc;

  // Pointer advance: free-running when DEPTH is a power of two, explicit wrap otherwise.
  generate
    if ((1 << PTR_W) == DEPTH) begin : g_pow2
      assign wr_inc = wr_ptr + 1'b1;
      assign rd_inc = rd_ptr + 1'b1;
    end else begin : g_wrap
      assign wr_inc = (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_inc = (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
    end
  endgenerate

  always_comb begin
    if (clr) count_nxt = '0;
    else     count_nxt = count + CNT_W'(push) - CNT_W'(pop);
  end

  assign rdata = slot[rd_ptr];

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (push && !clr && wr_ptr == PTR_W'(i)) slot[i] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_nxt;
      if (clr) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push) wr_ptr <= wr_inc;
        if (pop)  rd_ptr <= rd_inc;
      end
    end
  end
endmodule

// File: rtl/pfq_fetch.sv
module pfq_fetch
  import pfq_pkg::*;
#(
  parameter int   DEPTH   = 6,
  parameter int   CNT_W   = 3,
  parameter seg_t RST_SEG = 16'hF000,
  parameter off_t RST_OFF = 16'hFFF0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             redirect,
  input  seg_t             new_seg,
  input  off_t             new_off,
  input  logic             accept,
  input  logic [CNT_W-1:0] cnt_nxt,
  output seg_t             seg,
  output off_t             off,
  output logic             busy
);
  // A request is held while it waits, so "room next cycle" alone decides busy:
  // a waiting request implies the queue was not full and cannot fill without an accept.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seg  <= RST_SEG;
      off  <= RST_OFF;
      busy <= 1'b0;
    end else begin
      busy <= (cnt_nxt < CNT_W'(DEPTH));
      if (redirect) begin
        seg <= new_seg;
        off <= new_off;
      end else if (accept) begin
        off <= off + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pfq_top.sv
module pfq_top
  import pfq_pkg::*;
#(
  parameter int          DATA_W  = 8,
  parameter int          DEPTH   = 6,
  parameter logic [15:0] RST_SEG = 16'hF000,
  parameter logic [15:0] RST_OFF = 16'hFFF0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jump,
  input  logic [15:0]       jump_seg,
  input  logic [15:0]       jump_off,
  output logic              fetch_req,
  output logic [19:0]       fetch_addr,
  input  logic              fetch_ack,
  input  logic [DATA_W-1:0] fetch_data,
  output logic              byte_valid,
  output logic [DATA_W-1:0] byte_data,
  input  logic              byte_ready
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  seg_t             cur_seg;
  off_t             cur_off;
  logic             busy, push, pop;
  logic [CNT_W-1:0] occ, occ_nxt;

  assign fetch_req  = busy;
  assign byte_valid = (occ != '0);
  assign push       = fetch_ack && busy && !jump;
  assign pop        = byte_valid && byte_ready && !jump;

  pfq_fetch #(
    .DEPTH  (DEPTH),
    .CNT_W  (CNT_W),
    .RST_SEG(RST_SEG),
    .RST_OFF(RST_OFF)
  ) u_fetch (
    .clk     (clk),
    .rst_n   (rst_n),
    .redirect(jump),
    .new_seg (jump_seg),
    .new_off (jump_off),
    .accept  (push),
    .cnt_nxt (occ_nxt),
    .seg     (cur_seg),
    .off     (cur_off),
    .busy    (busy)
  );

  pfq_addr u_addr (
    .seg  (cur_seg),
    .off  (cur_off),
    .paddr(fetch_addr)
  );

  pfq_fifo #(
    .W    (DATA_W),
    .DEPTH(DEPTH)
  ) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (jump),
    .push     (push),
    .pop      (pop),
    .wdata    (fetch_data),
    .rdata    (byte_data),
    .count    (occ),
    .count_nxt(occ_nxt)
  );
endmodule

// File: rtl/pfq_checker.sv
module pfq_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 6,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              jump,
  input logic              fetch_req,
  input logic [19:0]       fetch_addr,
  input logic              fetch_ack,
  input logic              byte_valid,
  input logic [DATA_W-1:0] byte_data,
  input logic              byte_ready,
  input logic [CNT_W-1:0]  occ
);
  assert_occ_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  assert_no_req_full_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH)) |-> !fetch_req);

  assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && !fetch_ack && !jump) |=> (fetch_req && $stable(fetch_addr)));

  assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_ready && !jump) |=> (byte_valid && $stable(byte_data)));

  assert_jump_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    jump |=> (!byte_valid && fetch_req));

  assert_stream_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_req && fetch_ack && !jump && occ < CNT_W'(DEPTH - 1)) |=> fetch_req);

  assert_refill_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == CNT_W'(DEPTH) && byte_ready && !jump) |=> fetch_req);
endmodule

bind pfq_top pfq_checker #(
  .DATA_W(DATA_W),
  .DEPTH (DEPTH),
  .CNT_W (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .jump      (jump),
  .fetch_req (fetch_req),
  .fetch_addr(fetch_addr),
  .fetch_ack (fetch_ack),
  .byte_valid(byte_valid),
  .byte_data (byte_data),
  .byte_ready(byte_ready),
  .occ       (occ)
);

// File: tb/sim_pfq_top.sv
`timescale 1ns/1ps
module sim_pfq_top;
  localparam int DEPTH = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        jump = 1'b0;
  logic [15:0] jump_seg = '0;
  logic [15:0] jump_off = '0;
  logic        fetch_req;
  logic [19:0] fetch_addr;
  logic        fetch_ack = 1'b0;
  logic [7:0]  fetch_data = '0;
  logic        byte_valid;
  logic [7:0]  byte_data;
  logic        byte_ready = 1'b0;

  always #5 clk = ~clk;

  pfq_top #(.DATA_W(8), .DEPTH(DEPTH), .RST_SEG(16'hF000), .RST_OFF(16'hFFF0)) u0 (
    .clk(clk), .rst_n(rst_n), .jump(jump), .jump_seg(jump_seg), .jump_off(jump_off),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_ack(fetch_ack),
    .fetch_data(fetch_data), .byte_valid(byte_valid), .byte_data(byte_data),
    .byte_ready(byte_ready)
  );

  int total = 0;
  int fails = 0;
  bit done  = 0;

  // Reference model state
  logic [15:0] m_seg  = 16'hF000;
  logic [15:0] m_foff = 16'hFFF0;
  logic [15:0] m_coff = 16'hFFF0;
  int          m_occ  = 0;
  int          lat    = 0;
  int          wcnt   = 0;
  bit          prev_jump = 0;
  bit          prev_spur = 0;
  bit          lit_pend  = 0;
  logic [19:0] lit_addr  = '0;
  string       lit_tag   = "";
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [19:0] phys(input logic [15:0] s, input logic [15:0] o);
    int v;
    v = int'(s) * 16 + int'(o);
    return 20'(v % (1 << 20));
  endfunction

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ {a[3:0], a[19:16]} ^ a[15:8] ^ 8'h5A;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: check outputs, drive inputs, advance model, wait one cycle.
  task automatic step(input bit rdy, input bit fl, input logic [15:0] fs, input logic [15:0] fo,
                      input bit force_ack, input bit spur);
    bit ack, push, pop, spur_now;
    string t;
    logic [19:0] ea;
    t = (m_occ == DEPTH) ? "R1" : (prev_spur ? "R5" : (prev_jump ? "R7" : "R9"));
    check(fetch_req === (m_occ < DEPTH), t, 32'(fetch_req), 32'(m_occ < DEPTH));
    if (fetch_req) begin
      ea = phys(m_seg, m_foff);
      check(fetch_addr === ea, "R2 R3 R5", 32'(fetch_addr), 32'(ea));
    end
    if (lit_pend) begin
      check(fetch_addr === lit_addr, lit_tag, 32'(fetch_addr), 32'(lit_addr));
      lit_pend = 0;
    end
    check(byte_valid === (m_occ != 0), prev_jump ? "R7" : "R6", 32'(byte_valid), 32'(m_occ != 0));
    if (byte_valid && m_occ != 0) begin
      ea = phys(m_seg, m_coff);
      check(byte_data === mem_byte(ea), "R4 R6", 32'(byte_data), 32'(mem_byte(ea)));
    end
    ack = 0; spur_now = 0;
    if (fetch_req) begin
      if (force_ack || wcnt >= lat) begin ack = 1; wcnt = 0; end
      else wcnt++;
    end else begin
      wcnt = 0;
      ack = spur;
      spur_now = spur;
    end
    if (fl) wcnt = 0;
    fetch_ack  = ack;
    fetch_data = fetch_req ? mem_byte(fetch_addr) : 8'hEE;
    byte_ready = rdy;
    jump       = fl;
    jump_seg   = fs;
    jump_off   = fo;
    push = ack && fetch_req && !fl;
    pop  = byte_valid && rdy && !fl;
    if (fl) begin
      m_seg = fs; m_foff = fo; m_coff = fo; m_occ = 0;
      if (fs == 16'h1005 && fo == 16'h5555) begin lit_pend = 1; lit_addr = 20'h155A5; lit_tag = "R2"; end
      if (fs == 16'hFFFF && fo == 16'hFFF8) begin lit_pend = 1; lit_addr = 20'h0FFE8; lit_tag = "R2"; end
      if (fs == 16'h0000 && fo == 16'hFFFC) begin lit_pend = 1; lit_addr = 20'h0FFFC; lit_tag = "R3"; end
    end else begin
      if (push) begin m_foff = m_foff + 16'd1; m_occ++; end
      if (pop)  begin m_coff = m_coff + 16'd1; m_occ--; end
    end
    prev_jump = fl;
    prev_spur = spur_now;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    logic [15:0] tseg [4];
    logic [15:0] toff [4];
    tseg[0] = 16'hFFFF; toff[0] = 16'hFFF8;
    tseg[1] = 16'h1005; toff[1] = 16'h5555;
    tseg[2] = 16'h0000; toff[2] = 16'hFFFC;
    tseg[3] = 16'h1234; toff[3] = 16'h0000;
    repeat (3) @(negedge clk);
    // R8: outputs quiet in reset
    check(fetch_req === 1'b0, "R8", 32'(fetch_req), 0);
    check(byte_valid === 1'b0, "R8", 32'(byte_valid), 0);
    rst_n = 1'b1;
    lit_pend = 1; lit_addr = 20'hFFFF0; lit_tag = "R8";
    @(negedge clk);
    for (int l = 0; l < 4; l++) begin
      lat = l;
      for (int mode = 0; mode < 4; mode++) begin
        for (int c = 0; c < 250; c++) begin
          bit rdy, fl, fa, sp;
          logic [15:0] fs, fo;
          case (mode)
            0: rdy = 1'b1;
            1: rdy = (c % 9 == 0);
            2: rdy = c[0];
            default: rdy = lfsr[0];
          endcase
          fl = 0; fa = 0; fs = '0; fo = '0;
          if (c == 100) begin fl = 1; fs = tseg[(l + mode) % 4]; fo = toff[(l + mode) % 4]; end
          if (c == 180) begin fl = 1; fa = 1; fs = tseg[(l + mode + 1) % 4]; fo = toff[(l + mode + 1) % 4]; end
          sp = (mode == 1) && lfsr[3];
          step(rdy, fl, fs, fo, fa, sp);
        end
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule